// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a serial port that moves 8-bit characters over a data-out line, a data-in line and one shared serial clock. The host writes a byte into a holding register. The block loads that byte into a shift register and sends it least-significant bit first. Each bit changes on a falling clock edge, and the receiver samples the data-in line on rising edges. When both directions are enabled, every character sent also brings one character in over the same eight clock pulses.

The serial clock can come from either of two sources. The first is an internal divider of the system clock, in which case the block drives the clock pin. The second is an external clock pin, which the block synchronises and edge-detects before use. With only the receiver enabled on the internal clock, the block keeps producing characters on its own. It stops when an overrun occurs or when the receiver is disabled.

Disabling the transmitter empties it. Disabling the receiver leaves its data register and its flags exactly as they were.

Top module: `sync_serial_xcvr`

## Requirements
- R1: Transmitted bits leave least-significant bit first. `sd_out` changes only on a falling edge of the internal serial clock, so it is valid at the following rise. After the last bit, `sd_out` holds the value of bit 7.
- R2: The receiver samples `sd_in` on each rising serial-clock edge. The first sampled bit lands in bit 0 of `rdr_data`. `rd_rdr` clears `rdr_full`.
- R3: With `ext_mode`=0, `sck_oe` is 1. `sck_out` gives exactly 8 low pulses per character, and each low phase lasts `div_half`+2 system clocks. `sck_out` is 1 whenever no character is being shifted.
- R4: With `ext_mode`=1, `sck_oe` is 0. Shifting follows the edges of `sck_in`: data goes out after a fall and is sampled after a rise.
- R5: `wr_tdr` clears `tdr_empty`. Loading the shift register sets it again. With the transmitter enabled, a transfer starts only while `tdr_empty` is 0.
- R6: With `tx_en`=1 and `rx_en`=1, each transmitted character also receives one character into `rdr_data`.
- R7: With `rx_en`=1, `tx_en`=0 and the internal clock, characters are clocked in back to back without host writes. Clearing `rx_en` stops the clock at once.
- R8: If a character completes while `rdr_full` is 1, `ovr_flag` is set and the new character is discarded. No further character is clocked until `ovr_clr` is pulsed.
- R9: While `tx_en` is 0, `tdr_empty` reads 1, the pending byte is dropped, and a transfer in progress is abandoned, so no bits are sent.
- R10: Clearing `rx_en` leaves `rdr_data`, `rdr_full` and `ovr_flag` unchanged.
- R11: After reset, `tdr_empty`=1, `rdr_full`=0, `ovr_flag`=0, `sck_out`=1 and `sd_out`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_mode | input | 1 | 1 selects the external serial clock |
| div_half | input | DIV_W | Internal half period is this value plus 2 system clocks |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| wr_tdr | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | DATA_W | Byte to transmit |
| tdr_empty | output | 1 | Transmit holding register is empty |
| rd_rdr | input | 1 | Read strobe, clears rdr_full |
| rdr_data | output | DATA_W | Last received character |
| rdr_full | output | 1 | Receive register holds an unread character |
| ovr_clr | input | 1 | Clears the overrun flag |
| ovr_flag | output | 1 | Overrun occurred |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Internal serial clock to the pin |
| sck_oe | output | 1 | Output enable for the clock pin |
| sd_in | input | 1 | Serial data in |
| sd_out | output | 1 | Serial data out |

## Verification
The bench uses the default 8-bit character and a 4-bit divider. It drives `div_half` at 0, 1 and 3, which gives half periods of 2, 3 and 5 system clocks. The shortest setting makes the receive-only path restart one tail phase after each character, so the back-to-back overrun sequence happens within a few dozen cycles. The external-clock tests use a half period of 8 system clocks. That is long enough to cover the synchroniser latency, so both the abort after a transmitter disable and full-duplex traffic can be seen at the pins.

// File: rtl/sxc_pkg.sv
// Shared types for the clock-synchronous serial transceiver.
package sxc_pkg;
    // Transfer sequencer: idle, shifting bits, closing high phase.
    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_SHIFT = 2'd1,
        XS_TAIL  = 2'd2
    } xfer_st_t;
endpackage

// File: rtl/sxc_clkgen.sv
// Serial clock source. In internal mode, a divider ticks every div_half+2
// system clocks while a transfer runs, and the serial clock toggles on
// those ticks while shifting. In external mode, sck_in passes through a
// two-flop synchroniser and its edges become events.
// Assumes sck_in idles high and each external phase lasts at least 3 clocks.
module sxc_clkgen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode,
    input  logic             run,
    input  logic             shifting,
    input  logic [DIV_W-1:0] div_half,
    input  logic             sck_in,
    output logic             tick,
    output logic             fall_evt,
    output logic             rise_evt,
    output logic             sck_int
);
    localparam int CW = DIV_W + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic [2:0]    ext_sync;

    assign lim  = CW'(div_half) + CW'(1);
    assign tick = run && !ext_mode && (cnt == lim);

    // Half-period counter, held at zero while no transfer runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt == lim) cnt <= '0;
        else cnt <= cnt + CW'(1);
    end

    // Internal serial clock level: toggles on ticks while shifting, else high.
    always_ff @(posedge clk) begin
        if (!rst_n || !shifting) sck_int <= 1'b1;
        else if (tick) sck_int <= !sck_int;
    end

    // External clock synchroniser and edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sync <= 3'b111;
        else ext_sync <= {ext_sync[1:0], sck_in};
    end

    assign fall_evt = shifting && (ext_mode ? (ext_sync[2] && !ext_sync[1]) : (tick && sck_int));
    assign rise_evt = shifting && (ext_mode ? (!ext_sync[2] && ext_sync[1]) : (tick && !sck_int));
endmodule

// File: rtl/sxc_txshift.sv
// Transmit shift register. A load takes a whole character, and each shift
// puts the lowest remaining bit on the line. The line keeps its level
// between shifts, so it holds the last bit after a character ends.
module sxc_txshift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              sd_out
);
    logic [DATA_W-1:0] sh;

    // Shift register contents: clear, load or shift right.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sh <= '0;
        else if (load) sh <= load_data;
        else if (shift) sh <= sh >> 1;
    end

    // Line driver: takes the current lowest bit on each shift.
    always_ff @(posedge clk) begin
        if (!rst_n) sd_out <= 1'b1;
        else if (shift && !load) sd_out <= sh[0];
    end
endmodule

// File: rtl/sxc_rxshift.sv
// Receive shift register. Each sample enters at the top, so the first bit
// received ends up in bit 0. next_word is the character as it will look
// once the current sample has been taken.
module sxc_rxshift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              sd_in,
    output logic [DATA_W-1:0] next_word
);
    logic [DATA_W-1:0] sh;

    assign next_word = {sd_in, sh[DATA_W-1:1]};

    // Capture one bit per rising serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else if (sample) sh <= next_word;
    end
endmodule

// File: rtl/sync_serial_xcvr.sv
// Clock-synchronous serial transceiver top. It holds the host-side
// registers and flags and sequences 8-bit transfers over the shared
// serial clock. Assumes single-cycle host strobes that are synchronous to clk.
module sync_serial_xcvr
    import sxc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode,
    input  logic [DIV_W-1:0]  div_half,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              wr_tdr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tdr_empty,
    input  logic              rd_rdr,
    output logic [DATA_W-1:0] rdr_data,
    output logic              rdr_full,
    input  logic              ovr_clr,
    output logic              ovr_flag,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sd_in,
    output logic              sd_out
);
    localparam int BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    xfer_st_t          state;
    logic [BC_W-1:0]   bit_cnt;
    logic              tx_act, rx_act;
    logic [DATA_W-1:0] tdr;
    logic              busy, shifting;
    logic              tick, fall_evt, rise_evt, sck_int;
    logic              start_tx, start_rx, start, keep, abort_x, last_rise, done, full_now;
    logic [DATA_W-1:0] rx_next;

    assign busy     = (state != XS_IDLE);
    assign shifting = (state == XS_SHIFT);
    assign start_tx = tx_en && !tdr_empty && !(rx_en && ovr_flag);
    assign start_rx = rx_en && !tx_en && !ovr_flag;
    assign start    = !busy && (start_tx || start_rx);
    assign keep     = (tx_act && tx_en) || (rx_act && rx_en);
    assign abort_x  = busy && !keep;
    assign last_rise = shifting && rise_evt && (bit_cnt == BC_W'(DATA_W - 1));
    assign done     = last_rise && rx_act && rx_en;
    assign full_now = rdr_full && !rd_rdr;

    assign sck_out = sck_int || !shifting;
    assign sck_oe  = !ext_mode;

    sxc_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .run(busy),
        .shifting(shifting), .div_half(div_half), .sck_in(sck_in),
        .tick(tick), .fall_evt(fall_evt), .rise_evt(rise_evt), .sck_int(sck_int)
    );

    sxc_txshift #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr(!tx_en), .load(start && start_tx),
        .load_data(tdr), .shift(fall_evt && tx_act && tx_en), .sd_out(sd_out)
    );

    sxc_rxshift #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sample(rise_evt && rx_act && rx_en),
        .sd_in(sd_in), .next_word(rx_next)
    );

    // Transfer sequencer: start, count rising edges, close or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= XS_IDLE;
            bit_cnt <= '0;
        end else begin
            case (state)
                XS_IDLE: if (start) begin
                    state <= XS_SHIFT;
                    bit_cnt <= '0;
                end
                XS_SHIFT: if (abort_x) state <= XS_IDLE;
                    else if (rise_evt) begin
                        bit_cnt <= bit_cnt + BC_W'(1);
                        if (last_rise) state <= ext_mode ? XS_IDLE : XS_TAIL;
                    end
                XS_TAIL: if (abort_x || tick || ext_mode) state <= XS_IDLE;
                default: state <= XS_IDLE;
            endcase
        end
    end

    // Per-transfer roles, latched at start and dropped when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_act <= 1'b0;
            rx_act <= 1'b0;
        end else if (start) begin
            tx_act <= start_tx;
            rx_act <= rx_en;
        end else begin
            if (!tx_en) tx_act <= 1'b0;
            if (!rx_en) rx_act <= 1'b0;
        end
    end

    // Transmit holding register and its empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdr <= '0;
            tdr_empty <= 1'b1;
        end else begin
            if (wr_tdr) tdr <= wr_data;
            if (!tx_en) tdr_empty <= 1'b1;
            else if (wr_tdr) tdr_empty <= 1'b0;
            else if (start && start_tx) tdr_empty <= 1'b1;
        end
    end

    // Receive register, full flag and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdr_data <= '0;
            rdr_full <= 1'b0;
            ovr_flag <= 1'b0;
        end else begin
            if (done && !full_now) begin
                rdr_data <= rx_next;
                rdr_full <= 1'b1;
            end else if (rd_rdr) rdr_full <= 1'b0;
            if (done && full_now) ovr_flag <= 1'b1;
            else if (ovr_clr) ovr_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/sxc_checker.sv
// Protocol checker for the serial transceiver, attached to the top by bind.
module sxc_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_mode,
    input logic              tx_en,
    input logic              rx_en,
    input logic              rd_rdr,
    input logic              ovr_clr,
    input logic              busy,
    input logic              sck_out,
    input logic              sd_out,
    input logic              tdr_empty,
    input logic              rdr_full,
    input logic [DATA_W-1:0] rdr_data,
    input logic              ovr_flag
);
    logic       sck_q;
    logic [7:0] rise_cnt;

    // Count serial clock rises within one busy period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b1;
            rise_cnt <= '0;
        end else begin
            sck_q <= sck_out;
            if (!busy) rise_cnt <= '0;
            else if (sck_out && !sck_q) rise_cnt <= rise_cnt + 8'd1;
        end
    end

    a_r1_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && !$stable(sd_out)) |-> $fell(sck_out));
    a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_out);
    a_r3_max_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        rise_cnt <= 8'(DATA_W));
    a_r5_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tdr_empty) && $past(tx_en)) |-> busy);
    a_r8_ovr_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> ($stable(rdr_data) && rdr_full));
    a_r9_tx_off_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> tdr_empty);
    a_r10_rx_off_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && !rd_rdr && !ovr_clr) |=>
        ($stable(rdr_data) && $stable(rdr_full) && $stable(ovr_flag)));
endmodule

bind sync_serial_xcvr sxc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .tx_en(tx_en), .rx_en(rx_en),
    .rd_rdr(rd_rdr), .ovr_clr(ovr_clr), .busy(busy), .sck_out(sck_out),
    .sd_out(sd_out), .tdr_empty(tdr_empty), .rdr_full(rdr_full),
    .rdr_data(rdr_data), .ovr_flag(ovr_flag)
);

// File: tb/tb_sync_serial_xcvr.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_sync_serial_xcvr;
    localparam int DATA_W = 8;
    localparam int DIV_W  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_mode = 1'b0;
    logic [DIV_W-1:0] div_half = '0;
    logic tx_en = 1'b0, rx_en = 1'b0, wr_tdr = 1'b0, rd_rdr = 1'b0, ovr_clr = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic sck_in = 1'b1, sd_in = 1'b0;
    logic tdr_empty, rdr_full, ovr_flag, sck_out, sck_oe, sd_out;
    logic [DATA_W-1:0] rdr_data;

    int checks = 0, errors = 0;
    logic [63:0] feed = '0;
    logic [63:0] cap = '0;
    int fidx = 0, cidx = 0, low_min = 0, low_max = 0;

    always #5 clk = ~clk;

    sync_serial_xcvr #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .div_half(div_half),
        .tx_en(tx_en), .rx_en(rx_en), .wr_tdr(wr_tdr), .wr_data(wr_data),
        .tdr_empty(tdr_empty), .rd_rdr(rd_rdr), .rdr_data(rdr_data),
        .rdr_full(rdr_full), .ovr_clr(ovr_clr), .ovr_flag(ovr_flag),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .sd_in(sd_in),
        .sd_out(sd_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [DATA_W-1:0] b);
        @(negedge clk); wr_tdr = 1'b1; wr_data = b;
        @(negedge clk); wr_tdr = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd_rdr = 1'b1;
        @(negedge clk); rd_rdr = 1'b0;
    endtask

    // Follow the internal clock for n rises, feeding sd_in and capturing sd_out.
    task automatic int_pulses(input int n);
        int got = 0, lowlen = 0, tmo = 0;
        logic prev = sck_out;
        low_min = 999; low_max = 0;
        while (got < n && tmo < 5000) begin
            @(negedge clk); tmo++;
            if (prev && !sck_out) begin
                sd_in = feed[fidx & 63]; fidx++; lowlen = 1;
            end else if (!prev && sck_out) begin
                cap[cidx & 63] = sd_out; cidx++; got++;
                if (lowlen < low_min) low_min = lowlen;
                if (lowlen > low_max) low_max = lowlen;
            end else if (!sck_out) lowlen++;
            prev = sck_out;
        end
        if (tmo >= 5000) chk(1'b0, "R3 clock pulses missing", got, n);
    endtask

    // Drive n external clock pulses with the given half period.
    task automatic ext_pulses(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            sck_in = 1'b0; sd_in = feed[fidx & 63]; fidx++;
            repeat (half) @(negedge clk);
            cap[cidx & 63] = sd_out; cidx++;
            sck_in = 1'b1;
            repeat (half) @(negedge clk);
        end
    endtask

    // Count system cycles with the serial clock low over a window.
    task automatic count_low(input int cycles, output int lows);
        lows = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (!sck_out) lows++;
        end
    endtask

    task automatic t_reset();
        chk(tdr_empty == 1'b1, "R11 tdr_empty", tdr_empty, 1);
        chk(rdr_full == 1'b0, "R11 rdr_full", rdr_full, 0);
        chk(ovr_flag == 1'b0, "R11 ovr_flag", ovr_flag, 0);
        chk(sck_out == 1'b1, "R11 sck_out", sck_out, 1);
        chk(sd_out == 1'b1, "R11 sd_out", sd_out, 1);
        chk(sck_oe == 1'b1, "R3 sck_oe internal", sck_oe, 1);
    endtask

    task automatic t_tx_int(input logic [7:0] b, input logic [DIV_W-1:0] dv);
        int lows;
        ext_mode = 1'b0; div_half = dv; rx_en = 1'b0; tx_en = 1'b1; cidx = 0;
        @(negedge clk); wr_tdr = 1'b1; wr_data = b;
        @(negedge clk); wr_tdr = 1'b0;
        chk(tdr_empty == 1'b0, "R5 empty cleared by write", tdr_empty, 0);
        int_pulses(8);
        chk(cap[7:0] == b, "R1 lsb-first order", cap[7:0], b);
        chk(low_min == int'(dv) + 2 && low_max == int'(dv) + 2, "R3 low phase length", low_max, int'(dv) + 2);
        count_low(30, lows);
        chk(lows == 0, "R3 clock high when idle", lows, 0);
        chk(sd_out == b[7], "R1 line holds msb", sd_out, b[7]);
        chk(tdr_empty == 1'b1, "R5 empty set by load", tdr_empty, 1);
    endtask

    task automatic t_duplex(input logic [7:0] tb_, input logic [7:0] rb);
        int lows;
        ext_mode = 1'b0; div_half = 4'd1; tx_en = 1'b1; rx_en = 1'b1;
        feed[7:0] = rb; fidx = 0; cidx = 0;
        host_write(tb_);
        int_pulses(8);
        @(negedge clk);
        chk(cap[7:0] == tb_, "R6 duplex transmit", cap[7:0], tb_);
        chk(rdr_data == rb, "R6 duplex receive", rdr_data, rb);
        chk(rdr_full == 1'b1, "R2 full after char", rdr_full, 1);
        count_low(30, lows);
        chk(lows == 0, "R5 no start while empty", lows, 0);
        pulse_rd();
        chk(rdr_full == 1'b0, "R2 read clears full", rdr_full, 0);
    endtask

    task automatic t_rx_only();
        int lows;
        ext_mode = 1'b0; div_half = 4'd0; tx_en = 1'b0;
        feed = '0; feed[7:0] = 8'h81; feed[15:8] = 8'h42; feed[23:16] = 8'h18;
        feed[31:24] = 8'hE7; feed[39:32] = 8'h5A; fidx = 0;
        @(negedge clk); rx_en = 1'b1;
        int_pulses(8);
        chk(rdr_data == 8'h81 && rdr_full, "R7 free-running first char", rdr_data, 8'h81);
        int_pulses(8);
        chk(ovr_flag == 1'b1, "R8 overrun set", ovr_flag, 1);
        chk(rdr_data == 8'h81, "R8 new char discarded", rdr_data, 8'h81);
        count_low(40, lows);
        chk(lows == 0, "R8 clock stops on overrun", lows, 0);
        pulse_rd();
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        int_pulses(8);
        chk(rdr_data == 8'h18, "R8 resumes after clear", rdr_data, 8'h18);
        int_pulses(3);
        @(negedge clk); rx_en = 1'b0;
        count_low(30, lows);
        chk(lows <= 1, "R7 clearing rx_en stops clock", lows, 0);
        chk(rdr_data == 8'h18 && rdr_full, "R10 data and full kept", rdr_data, 8'h18);
        fidx = 32;
        @(negedge clk); rx_en = 1'b1;
        int_pulses(8);
        chk(ovr_flag == 1'b1, "R8 overrun again", ovr_flag, 1);
        @(negedge clk); rx_en = 1'b0;
        repeat (10) @(negedge clk);
        chk(ovr_flag == 1'b1, "R10 overrun kept", ovr_flag, 1);
        chk(rdr_data == 8'h18 && rdr_full, "R10 data kept with overrun", rdr_data, 8'h18);
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        pulse_rd();
    endtask

    task automatic t_ext(input logic [7:0] tb_, input logic [7:0] rb);
        ext_mode = 1'b1; tx_en = 1'b1; rx_en = 1'b1;
        @(negedge clk);
        chk(sck_oe == 1'b0, "R4 clock pin released", sck_oe, 0);
        feed[7:0] = rb; fidx = 0; cidx = 0;
        host_write(tb_);
        repeat (4) @(negedge clk);
        ext_pulses(8, 8);
        repeat (8) @(negedge clk);
        chk(cap[7:0] == tb_, "R4 external transmit", cap[7:0], tb_);
        chk(rdr_data == rb && rdr_full, "R4 external receive", rdr_data, rb);
        pulse_rd();
    endtask

    task automatic t_tx_clear();
        logic s0;
        ext_mode = 1'b1; rx_en = 1'b0; tx_en = 1'b1;
        host_write(8'h0F);
        host_write(8'hF0);
        chk(tdr_empty == 1'b0, "R5 second byte pending", tdr_empty, 0);
        @(negedge clk); tx_en = 1'b0;
        @(negedge clk);
        chk(tdr_empty == 1'b1, "R9 empty on disable", tdr_empty, 1);
        tx_en = 1'b1; s0 = sd_out; cidx = 0;
        repeat (4) @(negedge clk);
        ext_pulses(8, 8);
        chk(cap[7:0] == {8{s0}}, "R9 nothing sent after disable", cap[7:0], {8{s0}});
        chk(tdr_empty == 1'b1, "R9 still empty", tdr_empty, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_int(8'hB4, 4'd3);
        t_tx_int(8'h6B, 4'd0);
        t_duplex(8'hA5, 8'h3C);
        t_rx_only();
        t_ext(8'h6D, 8'hB2);
        t_tx_clear();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule